// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps every in-flight instruction of an out-of-order core in a circular queue, in the order the instructions were issued. At issue the front end asks for a slot and gets back a small tag. Execution units later write back a result under that tag. Until the instruction retires, the issue stage can read its value through the lookup ports. Only the oldest entry can retire, and only once its result is present. It then either writes the register file, writes memory, or simply leaves the queue.

Speculation is undone at the head. A branch can be marked as mispredicted when it writes back, and an instruction can carry an exception flag. Neither has any effect until that entry becomes the oldest. When it does, the buffer drops every entry in one cycle. For an exception it also reports the faulting entry's tag and program counter. Entries older than the faulting or mispredicted one have all retired by then, and nothing younger retires, so the restart point is precise.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `allocReady`=1, `allocTag`=0, no commit, flush or exception output is active, and every lookup returns ready=0.
- R2: Tags are handed out in strict issue order, incrementing by one per accepted allocation and wrapping from DEPTH-1 (7) back to 0.
- R3: With DEPTH entries occupied, `allocReady` is 0 and an allocation request is ignored. It takes no slot, so after k entries retire exactly k further allocations are accepted.
- R4: A writeback to an occupied entry stores its value, exception flag and mispredict flag, and marks the entry finished from the next cycle.
- R5: A lookup returns ready=1 and the stored value for an occupied, finished entry, and ready=0 for an occupied entry with no result yet or for an unoccupied entry.
- R6: Only the oldest entry retires, one per cycle, and only when finished. A finished younger entry waits behind an unfinished older one.
- R7: Kind encoding is 2'b00 register op, 2'b01 store, 2'b10 branch. On retiring, a register op pulses `regWrEn` with the low destination bits and the value. A store pulses `memWrEn` with the destination as address and the value. A correctly predicted branch retires with no write.
- R8: A finished mispredicted branch at the head pulses `flushOut` for one cycle with no write. All entries are discarded and the next allocation receives tag 0.
- R9: An exception flag is held silently until its entry is the head. There `excValid` pulses with the entry's tag and stored program counter, nothing is written for it or any younger entry, and the buffer empties.
- R10: A mispredict flag written back to a branch that is not yet the head causes no flush until every older entry has retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Issue stage requests an entry |
| allocKind | input | 2 | Instruction kind (00 reg, 01 store, 10 branch) |
| allocDest | input | DEST_W | Register number or memory address |
| allocPc | input | PC_W | Program counter of the instruction |
| allocReady | output | 1 | A free entry exists |
| allocTag | output | TagW | Tag the next accepted allocation receives |
| wbValid | input | 1 | Result writeback strobe |
| wbTag | input | TagW | Entry being written back |
| wbValue | input | DATA_W | Result value |
| wbExc | input | 1 | Instruction raised an exception |
| wbMiss | input | 1 | Branch was mispredicted |
| lkTag | input | NUM_LOOK*TagW | Packed lookup tags |
| lkReady | output | NUM_LOOK | Per-port value available |
| lkValue | output | NUM_LOOK*DATA_W | Packed lookup values |
| regWrEn | output | 1 | Register file write strobe |
| regWrIdx | output | REG_W | Register number |
| regWrData | output | DATA_W | Register write data |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | DEST_W | Memory address |
| memWrData | output | DATA_W | Memory write data |
| flushOut | output | 1 | Mispredict flush pulse |
| excValid | output | 1 | Precise exception pulse |
| excTag | output | TagW | Tag of faulting entry |
| excPc | output | PC_W | Program counter of faulting entry |

## Verification
The hardest case to reach is a flag that must stay silent. A mispredicted branch or a faulting instruction is already finished, and a younger entry is finished too, while an older entry is still waiting for its result. To set this up, the bench writes back results youngest first. It then checks that no commit event appears before it supplies the oldest result. An event log sampled every cycle records the exact order of retirements, flushes and exceptions, so it can show that nothing younger than the flagged entry ever reaches the register file or memory. The full-queue case is reached by issuing eight entries with no writeback, then requesting once more.

// File: rtl/spec_rob_pkg.sv
package spec_rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10
  } robKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic alloc;
    logic retire;
    logic flush;
  } robStrobe_t;
endpackage

// File: rtl/spec_rob_data.sv
module spec_rob_data
  import spec_rob_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int DATA_W   = 32,
  parameter int DEST_W   = 32,
  parameter int PC_W     = 32,
  parameter int NUM_LOOK = 2,
  localparam int TagW    = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  robStrobe_t               strobe,
  input  logic [TagW-1:0]          allocIdx,
  input  logic [1:0]               allocKind,
  input  logic [DEST_W-1:0]        allocDest,
  input  logic [PC_W-1:0]          allocPc,
  input  logic [TagW-1:0]          headIdx,
  input  logic                     wbValid,
  input  logic [TagW-1:0]          wbTag,
  input  logic [DATA_W-1:0]        wbValue,
  input  logic                     wbExc,
  input  logic                     wbMiss,
  input  logic [NUM_LOOK*TagW-1:0] lkTag,
  output logic [NUM_LOOK-1:0]      lkReady,
  output logic [NUM_LOOK*DATA_W-1:0] lkValue,
  output logic                     headValid,
  output logic                     headDone,
  output logic [1:0]               headKind,
  output logic [DEST_W-1:0]        headDest,
  output logic [DATA_W-1:0]        headValue,
  output logic                     headExc,
  output logic                     headMiss,
  output logic [PC_W-1:0]          headPc
);
  logic [DEPTH-1:0] entValid, entDone, entExc, entMiss;
  logic [1:0]        entKind  [DEPTH];
  logic [DEST_W-1:0] entDest  [DEPTH];
  logic [DATA_W-1:0] entValue [DEPTH];
  logic [PC_W-1:0]   entPc    [DEPTH];

  logic wbHit;
  assign wbHit = wbValid && entValid[wbTag] && !strobe.flush;

  // status bits, reset and flushed
  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      entValid <= '0;
      entDone  <= '0;
    end else begin
      if (strobe.retire) entValid[headIdx] <= 1'b0;
      if (strobe.alloc) begin
        entValid[allocIdx] <= 1'b1;
        entDone[allocIdx]  <= 1'b0;
      end
      if (wbHit) entDone[wbTag] <= 1'b1;
    end
  end

  // payload, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.alloc) begin
      entKind[allocIdx] <= allocKind;
      entDest[allocIdx] <= allocDest;
      entPc[allocIdx]   <= allocPc;
      entExc[allocIdx]  <= 1'b0;
      entMiss[allocIdx] <= 1'b0;
    end
    if (wbHit) begin
      entValue[wbTag] <= wbValue;
      entExc[wbTag]   <= wbExc;
      entMiss[wbTag]  <= wbMiss;
    end
  end

  generate
    for (genvar p = 0; p < NUM_LOOK; p++) begin : gLook
      logic [TagW-1:0] t;
      assign t = lkTag[p*TagW +: TagW];
      assign lkReady[p] = entValid[t] && entDone[t];
      assign lkValue[p*DATA_W +: DATA_W] = lkReady[p] ? entValue[t] : '0;
    end
  endgenerate

  assign headValid = entValid[headIdx];
  assign headDone  = entDone[headIdx];
  assign headKind  = entKind[headIdx];
  assign headDest  = entDest[headIdx];
  assign headValue = entValue[headIdx];
  assign headExc   = entExc[headIdx];
  assign headMiss  = entMiss[headIdx];
  assign headPc    = entPc[headIdx];

  assert_alloc_into_free_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |-> !entValid[allocIdx]);

  assert_wb_marks_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wbHit && !(strobe.retire && wbTag == headIdx)) |=> entDone[$past(wbTag)]);
endmodule

// File: rtl/spec_rob_ctrl.sv
module spec_rob_ctrl
  import spec_rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 32,
  parameter int PC_W   = 32,
  parameter int REG_W  = 5,
  localparam int TagW  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic              headValid,
  input  logic              headDone,
  input  logic [1:0]        headKind,
  input  logic [DEST_W-1:0] headDest,
  input  logic [DATA_W-1:0] headValue,
  input  logic              headExc,
  input  logic              headMiss,
  input  logic [PC_W-1:0]   headPc,
  output robStrobe_t        strobe,
  output logic [TagW-1:0]   allocIdx,
  output logic [TagW-1:0]   headIdx,
  output logic              allocReady,
  output logic              regWrEn,
  output logic [REG_W-1:0]  regWrIdx,
  output logic [DATA_W-1:0] regWrData,
  output logic              memWrEn,
  output logic [DEST_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              flushOut,
  output logic              excValid,
  output logic [TagW-1:0]   excTag,
  output logic [PC_W-1:0]   excPc
);
  logic [TagW:0] headPtr, tailPtr;
  logic full, empty, commitGo, excFire, missFire;

  assign empty = (headPtr == tailPtr);
  assign full  = (headPtr[TagW] != tailPtr[TagW]) &&
                 (headPtr[TagW-1:0] == tailPtr[TagW-1:0]);
  assign allocReady = !full;
  assign allocIdx   = tailPtr[TagW-1:0];
  assign headIdx    = headPtr[TagW-1:0];

  assign commitGo = headValid && headDone;
  assign excFire  = commitGo && headExc;
  assign missFire = commitGo && !headExc && headKind == KIND_BRANCH && headMiss;

  always_comb begin
    strobe.flush  = excFire || missFire;
    strobe.retire = commitGo && !strobe.flush;
    strobe.alloc  = allocValid && !full && !strobe.flush;
  end

  assign regWrEn   = strobe.retire && headKind == KIND_REG;
  assign regWrIdx  = headDest[REG_W-1:0];
  assign regWrData = headValue;
  assign memWrEn   = strobe.retire && headKind == KIND_STORE;
  assign memWrAddr = headDest;
  assign memWrData = headValue;
  assign flushOut  = missFire;
  assign excValid  = excFire;
  assign excTag    = headIdx;
  assign excPc     = headPc;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (strobe.retire) headPtr <= headPtr + 1'b1;
      if (strobe.alloc)  tailPtr <= tailPtr + 1'b1;
    end
  end

  assert_fill_limit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (TagW+1)'(tailPtr - headPtr) <= (TagW+1)'(DEPTH));

  assert_head_matches_ptrs_R1: assert property (@(posedge clk) disable iff (!rstN)
    headValid == !empty);

  assert_tag_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |=> tailPtr == (TagW+1)'($past(tailPtr) + 1'b1));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flushOut || excValid) |=> (headPtr == '0 && tailPtr == '0));
endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import spec_rob_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int DATA_W   = 32,
  parameter int DEST_W   = 32,
  parameter int PC_W     = 32,
  parameter int REG_W    = 5,
  parameter int NUM_LOOK = 2,
  localparam int TagW    = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       allocValid,
  input  logic [1:0]                 allocKind,
  input  logic [DEST_W-1:0]          allocDest,
  input  logic [PC_W-1:0]            allocPc,
  output logic                       allocReady,
  output logic [TagW-1:0]            allocTag,
  input  logic                       wbValid,
  input  logic [TagW-1:0]            wbTag,
  input  logic [DATA_W-1:0]          wbValue,
  input  logic                       wbExc,
  input  logic                       wbMiss,
  input  logic [NUM_LOOK*TagW-1:0]   lkTag,
  output logic [NUM_LOOK-1:0]        lkReady,
  output logic [NUM_LOOK*DATA_W-1:0] lkValue,
  output logic                       regWrEn,
  output logic [REG_W-1:0]           regWrIdx,
  output logic [DATA_W-1:0]          regWrData,
  output logic                       memWrEn,
  output logic [DEST_W-1:0]          memWrAddr,
  output logic [DATA_W-1:0]          memWrData,
  output logic                       flushOut,
  output logic                       excValid,
  output logic [TagW-1:0]            excTag,
  output logic [PC_W-1:0]            excPc
);
  robStrobe_t        strobe;
  logic [TagW-1:0]   allocIdx, headIdx;
  logic              headValid, headDone, headExc, headMiss;
  logic [1:0]        headKind;
  logic [DEST_W-1:0] headDest;
  logic [DATA_W-1:0] headValue;
  logic [PC_W-1:0]   headPc;

  assign allocTag = allocIdx;

  spec_rob_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W),
                  .PC_W(PC_W), .REG_W(REG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid),
    .headValid(headValid), .headDone(headDone), .headKind(headKind),
    .headDest(headDest), .headValue(headValue), .headExc(headExc),
    .headMiss(headMiss), .headPc(headPc), .strobe(strobe),
    .allocIdx(allocIdx), .headIdx(headIdx), .allocReady(allocReady),
    .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrData(regWrData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .flushOut(flushOut), .excValid(excValid), .excTag(excTag), .excPc(excPc)
  );

  spec_rob_data #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W),
                  .PC_W(PC_W), .NUM_LOOK(NUM_LOOK)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allocIdx(allocIdx),
    .allocKind(allocKind), .allocDest(allocDest), .allocPc(allocPc),
    .headIdx(headIdx), .wbValid(wbValid), .wbTag(wbTag), .wbValue(wbValue),
    .wbExc(wbExc), .wbMiss(wbMiss), .lkTag(lkTag), .lkReady(lkReady),
    .lkValue(lkValue), .headValid(headValid), .headDone(headDone),
    .headKind(headKind), .headDest(headDest), .headValue(headValue),
    .headExc(headExc), .headMiss(headMiss), .headPc(headPc)
  );
endmodule

// File: tb/sim_spec_rob.sv
`timescale 1ns/1ps
module sim_spec_rob;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        allocValid = 0;
  logic [1:0]  allocKind = 0;
  logic [31:0] allocDest = 0, allocPc = 0;
  logic        allocReady;
  logic [2:0]  allocTag;
  logic        wbValid = 0, wbExc = 0, wbMiss = 0;
  logic [2:0]  wbTag = 0;
  logic [31:0] wbValue = 0;
  logic [5:0]  lkTag = 0;
  logic [1:0]  lkReady;
  logic [63:0] lkValue;
  logic        regWrEn, memWrEn, flushOut, excValid;
  logic [4:0]  regWrIdx;
  logic [31:0] regWrData, memWrAddr, memWrData, excPc;
  logic [2:0]  excTag;

  spec_rob u0 (.*);

  int nChecks = 0, nBad = 0;
  int logN = 0;
  int logType [0:255];
  logic [31:0] logX [0:255];
  logic [31:0] logY [0:255];

  // event log: 1 reg write, 2 mem write, 3 flush, 4 exception
  always @(negedge clk) begin
    if (rstN) begin
      if (regWrEn)  begin logType[logN] = 1; logX[logN] = 32'(regWrIdx); logY[logN] = regWrData; logN++; end
      if (memWrEn)  begin logType[logN] = 2; logX[logN] = memWrAddr; logY[logN] = memWrData; logN++; end
      if (flushOut) begin logType[logN] = 3; logX[logN] = 0; logY[logN] = 0; logN++; end
      if (excValid) begin logType[logN] = 4; logX[logN] = 32'(excTag); logY[logN] = excPc; logN++; end
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic alloc(logic [1:0] k, logic [31:0] d, logic [31:0] pc, logic [2:0] expTag, string req);
    allocValid = 1; allocKind = k; allocDest = d; allocPc = pc;
    #1 check(req, {63'd0, allocReady}, 64'd1);
    check(req, 64'(allocTag), 64'(expTag));
    step(); allocValid = 0;
  endtask

  task automatic wb(logic [2:0] t, logic [31:0] v, logic e, logic m);
    wbValid = 1; wbTag = t; wbValue = v; wbExc = e; wbMiss = m;
    step(); wbValid = 0; wbExc = 0; wbMiss = 0;
  endtask

  task automatic look(logic [2:0] t, logic expRdy, logic [31:0] expVal, string req);
    lkTag[2:0] = t; #1;
    check(req, {63'd0, lkReady[0]}, {63'd0, expRdy});
    if (expRdy) check(req, {32'd0, lkValue[31:0]}, {32'd0, expVal});
  endtask

  task automatic expEv(int idx, int typ, logic [31:0] x, logic [31:0] y, string req);
    check(req, 64'(logType[idx]), 64'(typ));
    check(req, {logX[idx], logY[idx]}, {x, y});
  endtask

  task automatic testReset();
    #1;
    check("R1 ready", {63'd0, allocReady}, 64'd1);
    check("R1 tag", 64'(allocTag), 64'd0);
    check("R1 outs", {60'd0, regWrEn, memWrEn, flushOut, excValid}, 64'd0);
    lkTag = 6'b000_000; #1;
    check("R1 lookup", 64'(lkReady), 64'd0);
  endtask

  task automatic testFill();
    int base = logN;
    for (int i = 0; i < 8; i++)
      alloc(2'b00, 32'(i + 1), 32'h100 + 32'(4 * i), 3'(i), "R2 tag order");
    #1 check("R3 full", {63'd0, allocReady}, 64'd0);
    allocValid = 1; allocDest = 99; step(); allocValid = 0;
    look(3, 0, 0, "R5 pending");
    wb(1, 32'h111, 0, 0);
    look(1, 1, 32'h111, "R4 R5 captured");
    lkTag[5:3] = 3'd1; #1 check("R5 port B", {31'd0, lkValue[63:32]}, 64'h111);
    check("R6 no early commit", 64'(logN - base), 64'd0);
    wb(0, 32'h100, 0, 0);
    step(3);
    check("R6 two commits", 64'(logN - base), 64'd2);
    expEv(base, 1, 1, 32'h100, "R7 reg commit");
    expEv(base + 1, 1, 2, 32'h111, "R6 order");
    alloc(2'b00, 20, 0, 0, "R2 wrap");
    alloc(2'b00, 21, 0, 1, "R3 freed slots");
    #1 check("R3 full again", {63'd0, allocReady}, 64'd0);
    for (int i = 2; i < 8; i++) wb(3'(i), 32'h200 + 32'(i), 0, 0);
    wb(0, 32'h300, 0, 0);
    wb(1, 32'h301, 0, 0);
    step(3);
    check("R6 drain count", 64'(logN - base), 64'd10);
    for (int i = 2; i < 8; i++) expEv(base + i, 1, 32'(i + 1), 32'h200 + 32'(i), "R6 drain order");
    expEv(base + 8, 1, 20, 32'h300, "R3 no ghost entry");
    expEv(base + 9, 1, 21, 32'h301, "R3 no ghost entry");
  endtask

  task automatic testKinds();
    int base = logN;
    alloc(2'b01, 32'h1000, 0, 2, "R7 store alloc");
    alloc(2'b10, 0, 0, 3, "R7 branch alloc");
    alloc(2'b00, 5, 0, 4, "R7 reg alloc");
    wb(4, 32'h44, 0, 0);
    wb(3, 0, 0, 0);
    wb(2, 32'hAB, 0, 0);
    step(4);
    check("R7 event count", 64'(logN - base), 64'd2);
    expEv(base, 2, 32'h1000, 32'hAB, "R7 store");
    expEv(base + 1, 1, 5, 32'h44, "R7 branch silent");
  endtask

  task automatic testMiss();
    int base = logN;
    alloc(2'b00, 6, 0, 5, "R10 alloc");
    alloc(2'b10, 0, 0, 6, "R10 alloc");
    alloc(2'b00, 7, 0, 7, "R10 alloc");
    wb(6, 0, 0, 1);
    wb(7, 32'h77, 0, 0);
    step();
    check("R10 no early flush", 64'(logN - base), 64'd0);
    look(7, 1, 32'h77, "R5 younger ready");
    wb(5, 32'h55, 0, 0);
    step(3);
    check("R8 events", 64'(logN - base), 64'd2);
    expEv(base, 1, 6, 32'h55, "R10 older retires first");
    expEv(base + 1, 3, 0, 0, "R8 flush");
    look(7, 0, 0, "R8 discarded");
    alloc(2'b00, 9, 0, 0, "R8 restart tag");
    wb(0, 9, 0, 0);
    step(2);
    expEv(base + 2, 1, 9, 9, "R8 after flush");
  endtask

  task automatic testExc();
    int base = logN;
    alloc(2'b00, 10, 32'h40, 1, "R9 alloc");
    alloc(2'b00, 11, 32'h44, 2, "R9 alloc");
    alloc(2'b00, 12, 32'h48, 3, "R9 alloc");
    wb(2, 32'hEE, 1, 0);
    wb(3, 32'h33, 0, 0);
    step();
    check("R9 deferred", 64'(logN - base), 64'd0);
    wb(1, 32'h11, 0, 0);
    step(3);
    check("R9 events", 64'(logN - base), 64'd2);
    expEv(base, 1, 10, 32'h11, "R9 older commits");
    expEv(base + 1, 4, 2, 32'h44, "R9 exception tag pc");
    alloc(2'b00, 13, 0, 0, "R9 emptied");
  endtask

  initial begin
    #(8 * 100000);
    nBad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1;
    testReset();
    testFill();
    testKinds();
    testMiss();
    testExc();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule